// File: doc/BRIEF.md
# Flash Status and Write-Protect Guard

This block keeps the protection state of a small serial flash array and judges every write the command decoder wants to start. It holds a write-enable latch, two block-protect bits that choose how much of the array is locked, and a bit that lets the external write-protect pin guard the status register. The command decoder drives enable and disable strobes and status-write commits into the block. It also sends program and erase requests with their target address. The block answers each request one cycle later with an allow/deny verdict and a mask of the sectors the operation may touch. It also assembles the status byte that the host reads back.

Once a request is allowed, the block stays busy until the program/erase sequencer reports the end of the cycle. A status write runs as a fixed-length busy cycle of its own. When either kind of cycle ends, the write-enable latch is cleared. The pin is synchronised inside the block. If it falls while a status-write frame is open and pin protection is armed, that frame's commit is voided.

Two channels carry data into the block: the status-write commit and the write request. Each is a valid/ready pair. A transfer happens in a cycle where both are high. Ready is low for the whole of a busy cycle. When both channels are valid in the same idle cycle, the write request wins and the status-write ready drops. The upstream side must hold valid and its payload steady until ready is seen.

Top module: `prot_guard`

## Requirements
- R1: After reset the status byte reads 0x00, no verdict is pending, and both ready outputs are high.
- R2: Layout of the status byte: bit 7 is the pin-protect arm bit, bits 6..4 read 0, bit 3 and bit 2 are the upper and lower protect-level bits, bit 1 is the write-enable latch, and bit 0 is busy.
- R3: When idle, `wen_set_i` sets the latch and `wen_clr_i` clears it whatever the pin level. Clear wins over set. Both strobes are ignored while busy and in any cycle that accepts a transfer.
- R4: The sector index is the top two address bits (bits 16:15). Protect level 00 locks nothing, 01 locks sector 3 (0x18000..0x1FFFF), 10 locks sectors 2 and 3 (0x10000..0x1FFFF), and 11 locks all four.
- R5: A write request (kind 0 program, 1 sector erase, 2 chip erase, 3 reserved) gives `dec_valid_o` one cycle after acceptance. Program and sector erase are allowed only if the latch is set and the addressed sector is unlocked; the mask is that sector. Chip erase is allowed only if the latch is set and at least one sector is unlocked; the mask is every unlocked sector. Kind 3 is always denied, and a denied verdict has a zero mask. The pin plays no part in this verdict.
- R6: An allowed request makes busy high from the verdict cycle until the cycle after `done_i`. After that, busy and the latch are both 0. `done_i` has no effect at other times.
- R7: A status-write commit is taken only when the latch is set, pin protection is not active (active means synchronised pin low and arm bit 1), and the frame was not voided. It loads the arm bit from data bit 7 and the level bits from data bits 3:2; the other data bits are ignored. A refused commit changes nothing, the latch included.
- R8: An accepted status write keeps busy high for SRW_CYCLES cycles. Then busy and the latch both read 0.
- R9: When the synchronised pin falls while `srw_open_i` is high and the arm bit is 1, the commit of that frame is refused, even if the pin has gone high again by then. The voiding ends when `srw_open_i` drops.
- R10: The pin passes through SYNC_STAGES flops before protection reacts. SYNC_STAGES+1 cycles after the pin goes low with the arm bit set, status writes are refused.
- R11: `op_ready_o` is the inverse of busy. `srw_ready_o` is high only when idle and no write request is valid.
- R12: With the arm bit 0, a low pin does not block status writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wp_n_i | input | 1 | Write-protect pin, low = protect request |
| wen_set_i | input | 1 | Write-enable strobe |
| wen_clr_i | input | 1 | Write-disable strobe |
| srw_open_i | input | 1 | A status-write frame is being received |
| srw_valid_i | input | 1 | Status-write commit valid |
| srw_data_i | input | 8 | Status-write data byte |
| srw_ready_o | output | 1 | Status-write commit ready |
| op_valid_i | input | 1 | Write request valid |
| op_kind_i | input | 2 | Request kind: 0 program, 1 sector erase, 2 chip erase |
| op_addr_i | input | 17 | Request byte address |
| op_ready_o | output | 1 | Write request ready |
| done_i | input | 1 | Sequencer end-of-cycle pulse |
| dec_valid_o | output | 1 | Verdict pulse |
| dec_allow_o | output | 1 | Verdict: 1 allowed |
| dec_mask_o | output | 4 | Sectors the allowed operation may touch |
| status_o | output | 8 | Status byte |

## Verification
The lock map is tried with addresses on both sides of each level's boundary (0x17FFF against 0x18000, low sector against top sector). Each request kind is tried at every protect level, so a wrong boundary or a wrong chip-erase mask shows up as a different verdict. The status path is driven with the pin high, with the pin held low and the arm bit set, with the pin held low and the arm bit clear, and with a pin glitch inside an open frame. These four cases separate pin protection, arm-bit gating and frame voiding. Strobes and `done_i` are also sent while busy and while idle, to show that each is ignored at the right time.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM    = 2'd0,
    OP_SECT_ERASE = 2'd1,
    OP_CHIP_ERASE = 2'd2,
    OP_RSVD       = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_STATUS = 2'd1,
    CYC_ARRAY  = 2'd2
  } cyc_e;

  typedef struct packed {
    logic       arm;
    logic [1:0] lvl;
  } prot_cfg_t;

endpackage

// File: rtl/prot_lock_map.sv
module prot_lock_map
  import prot_guard_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 2
) (
  input  logic [1:0]              lvl_i,
  input  op_kind_e                kind_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [(1<<SECT_W)-1:0]  mask_o
);
  localparam int NSECT = 1 << SECT_W;
  localparam logic [SECT_W:0] LIM_NONE = (SECT_W+1)'(NSECT);
  localparam logic [SECT_W:0] LIM_QTR  = (SECT_W+1)'(NSECT - NSECT/4);
  localparam logic [SECT_W:0] LIM_HALF = (SECT_W+1)'(NSECT/2);

  // Sectors at or above lim are locked.
  logic [SECT_W:0]   lim;
  logic [SECT_W-1:0] sel;
  logic              unused_addr;

  assign sel         = addr_i[ADDR_W-1 -: SECT_W];
  assign unused_addr = ^addr_i[ADDR_W-SECT_W-1:0];

  always_comb begin
    case (lvl_i)
      2'b00:   lim = LIM_NONE;
      2'b01:   lim = LIM_QTR;
      2'b10:   lim = LIM_HALF;
      default: lim = '0;
    endcase
  end

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    localparam logic [SECT_W:0] IDX = (SECT_W+1)'(g);
    logic hit;
    always_comb begin
      case (kind_i)
        OP_PROGRAM, OP_SECT_ERASE: hit = (sel == IDX[SECT_W-1:0]);
        OP_CHIP_ERASE:             hit = 1'b1;
        default:                   hit = 1'b0;
      endcase
    end
    assign mask_o[g] = hit && (IDX < lim);
  end

endmodule

// File: rtl/prot_wp_sync.sv
module prot_wp_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n_i,
  input  logic arm_i,
  input  logic srw_open_i,
  output logic hw_prot_o,
  output logic void_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   void_q;
  logic                   wp_s;
  logic                   fall;

  if (SYNC_STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= wp_n_i;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], wp_n_i};
    end
  end

  assign wp_s = sync_q[SYNC_STAGES-1];
  assign fall = prev_q & ~wp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      void_q <= 1'b0;
    end else begin
      prev_q <= wp_s;
      void_q <= srw_open_i & void_o;
    end
  end

  assign hw_prot_o = ~wp_s & arm_i;
  assign void_o    = void_q | (srw_open_i & fall & arm_i);

  AST_VOID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (srw_open_i && void_o) |=> (!srw_open_i || void_o)); // R9

endmodule

// File: rtl/prot_cycle_timer.sv
module prot_cycle_timer
  import prot_guard_pkg::*;
#(
  parameter int SRW_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_status_i,
  input  logic start_array_i,
  input  logic done_i,
  output logic busy_o,
  output logic end_o
);
  localparam int CW = $clog2(SRW_CYCLES + 1);

  cyc_e          kind_q;
  logic [CW-1:0] cnt_q;

  assign busy_o = (kind_q != CYC_IDLE);
  assign end_o  = ((kind_q == CYC_STATUS) && (cnt_q == CW'(1))) ||
                  ((kind_q == CYC_ARRAY) && done_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CYC_IDLE;
      cnt_q  <= '0;
    end else if (end_o) begin
      kind_q <= CYC_IDLE;
      cnt_q  <= '0;
    end else if (start_status_i) begin
      kind_q <= CYC_STATUS;
      cnt_q  <= CW'(SRW_CYCLES);
    end else if (start_array_i) begin
      kind_q <= CYC_ARRAY;
    end else if (kind_q == CYC_STATUS) begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  AST_ARRAY_WAITS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_q == CYC_ARRAY) && !done_i) |=> busy_o); // R6
  AST_STATUS_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_q == CYC_STATUS) && (cnt_q > CW'(1))) |=> busy_o); // R8
  AST_NO_DOUBLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_status_i && start_array_i)); // R11

endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_guard_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SECT_W      = 2,
  parameter int SRW_CYCLES  = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wp_n_i,
  input  logic                    wen_set_i,
  input  logic                    wen_clr_i,
  input  logic                    srw_open_i,
  input  logic                    srw_valid_i,
  input  logic [7:0]              srw_data_i,
  output logic                    srw_ready_o,
  input  logic                    op_valid_i,
  input  logic [1:0]              op_kind_i,
  input  logic [ADDR_W-1:0]       op_addr_i,
  output logic                    op_ready_o,
  input  logic                    done_i,
  output logic                    dec_valid_o,
  output logic                    dec_allow_o,
  output logic [(1<<SECT_W)-1:0]  dec_mask_o,
  output logic [7:0]              status_o
);
  localparam int NSECT = 1 << SECT_W;

  prot_cfg_t        cfg_q;
  logic             wen_q;
  logic             busy;
  logic             cyc_end;
  logic             hw_prot;
  logic             frame_void;
  logic [NSECT-1:0] mask_c;
  logic             allow_c;
  logic             op_fire;
  logic             srw_fire;
  logic             srw_ok;
  logic             unused_data;

  assign unused_data = ^{srw_data_i[6:4], srw_data_i[1:0]};

  prot_lock_map #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_map (
    .lvl_i  (cfg_q.lvl),
    .kind_i (op_kind_e'(op_kind_i)),
    .addr_i (op_addr_i),
    .mask_o (mask_c)
  );

  prot_wp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_wp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n_i     (wp_n_i),
    .arm_i      (cfg_q.arm),
    .srw_open_i (srw_open_i),
    .hw_prot_o  (hw_prot),
    .void_o     (frame_void)
  );

  prot_cycle_timer #(.SRW_CYCLES(SRW_CYCLES)) u_cyc (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_status_i (srw_fire && srw_ok),
    .start_array_i  (op_fire && allow_c),
    .done_i         (done_i),
    .busy_o         (busy),
    .end_o          (cyc_end)
  );

  assign op_ready_o  = !busy;
  assign srw_ready_o = !busy && !op_valid_i;
  assign op_fire     = op_valid_i && op_ready_o;
  assign srw_fire    = srw_valid_i && srw_ready_o;
  assign allow_c     = wen_q && (|mask_c);
  assign srw_ok      = wen_q && !hw_prot && !frame_void;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      wen_q       <= 1'b0;
      dec_valid_o <= 1'b0;
      dec_allow_o <= 1'b0;
      dec_mask_o  <= '0;
    end else begin
      dec_valid_o <= op_fire;
      dec_allow_o <= op_fire && allow_c;
      dec_mask_o  <= (op_fire && allow_c) ? mask_c : '0;
      if (srw_fire && srw_ok) begin
        cfg_q.arm <= srw_data_i[7];
        cfg_q.lvl <= srw_data_i[3:2];
      end
      if (cyc_end) begin
        wen_q <= 1'b0;
      end else if (!busy && !op_fire && !srw_fire) begin
        if (wen_clr_i)      wen_q <= 1'b0;
        else if (wen_set_i) wen_q <= 1'b1;
      end
    end
  end

  assign status_o = {cfg_q.arm, 3'b000, cfg_q.lvl, wen_q, busy};

  AST_WEN_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wen_q); // R6
  AST_ALLOW_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && dec_allow_o) |-> $past(wen_q)); // R5
  AST_FULL_LOCK_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && ($past(cfg_q.lvl) == 2'b11)) |-> !dec_allow_o); // R4
  AST_HW_FREEZES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hw_prot) |-> $stable(cfg_q)); // R7
  AST_BUSY_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q)); // R3
  AST_ALLOW_HAS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && dec_allow_o) |-> ($countones(dec_mask_o) >= 1)); // R5

endmodule

// File: tb/prot_guard_bench.sv
module prot_guard_bench;
  localparam int SRW = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_n = 1'b1, wen_set = 1'b0, wen_clr = 1'b0, srw_open = 1'b0;
  logic       srw_valid = 1'b0, op_valid = 1'b0, done = 1'b0;
  logic [7:0] srw_data = '0;
  logic [1:0] op_kind = '0;
  logic [16:0] op_addr = '0;
  logic       srw_ready, op_ready, dec_valid, dec_allow;
  logic [3:0] dec_mask;
  logic [7:0] status;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prot_guard #(.SRW_CYCLES(SRW)) u_prot_guard (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .wen_set_i(wen_set),
    .wen_clr_i(wen_clr), .srw_open_i(srw_open), .srw_valid_i(srw_valid),
    .srw_data_i(srw_data), .srw_ready_o(srw_ready), .op_valid_i(op_valid),
    .op_kind_i(op_kind), .op_addr_i(op_addr), .op_ready_o(op_ready),
    .done_i(done), .dec_valid_o(dec_valid), .dec_allow_o(dec_allow),
    .dec_mask_o(dec_mask), .status_o(status)
  );

  // Behavioural reference model
  int m_arm, m_lvl, m_wen, m_busy, m_kind, m_cnt, m_dv, m_da, m_dm;
  int h1, h2, hp, m_void;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_arm = 0; m_lvl = 0; m_wen = 0; m_busy = 0; m_kind = 0; m_cnt = 0;
      m_dv = 0; m_da = 0; m_dm = 0; h1 = 1; h2 = 1; hp = 1; m_void = 0;
    end else begin
      int fall, hw, veff, first, sect, mask;
      fall = (hp == 1 && h2 == 0);
      hw = (h2 == 0 && m_arm == 1);
      veff = m_void || (srw_open && fall && m_arm);
      m_dv = 0; m_da = 0; m_dm = 0;
      if (m_busy) begin
        if (m_kind == 1) begin
          if (m_cnt == 1) begin m_busy = 0; m_wen = 0; end
          else m_cnt = m_cnt - 1;
        end else if (done) begin
          m_busy = 0; m_wen = 0;
        end
      end else if (op_valid) begin
        first = (m_lvl == 0) ? 4 : (m_lvl == 1) ? 3 : (m_lvl == 2) ? 2 : 0;
        sect = int'(op_addr) / 32768;
        mask = 0;
        for (int s = 0; s < 4; s++)
          if (s < first && (op_kind == 2 || (op_kind < 2 && s == sect)))
            mask = mask | (1 << s);
        m_dv = 1;
        m_da = (m_wen == 1 && mask != 0);
        m_dm = m_da ? mask : 0;
        if (m_da) begin m_busy = 1; m_kind = 2; end
      end else if (srw_valid) begin
        if (m_wen == 1 && !hw && !veff) begin
          m_arm = srw_data[7]; m_lvl = srw_data[3:2];
          m_busy = 1; m_kind = 1; m_cnt = SRW;
        end
      end else begin
        if (wen_clr) m_wen = 0;
        else if (wen_set) m_wen = 1;
      end
      m_void = srw_open ? veff : 0;
      hp = h2; h2 = h1; h1 = wp_n;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int m_status;
  task automatic step();
    #1;
    chk(op_ready == !m_busy, "R11 op_ready", op_ready, !m_busy);
    chk(srw_ready == (!m_busy && !op_valid), "R11 srw_ready", srw_ready,
        (!m_busy && !op_valid));
    @(posedge clk);
    #2;
    m_status = (m_arm << 7) | (m_lvl << 2) | (m_wen << 1) | m_busy;
    chk(status == 8'(m_status), "R2 status model", status, m_status);
    chk(dec_valid == 1'(m_dv), "R5 dec_valid model", dec_valid, m_dv);
    chk(dec_allow == 1'(m_da), "R5 dec_allow model", dec_allow, m_da);
    chk(dec_mask == 4'(m_dm), "R5 dec_mask model", dec_mask, m_dm);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wen(bit s, bit c);
    wen_set = s; wen_clr = c; step(); wen_set = 0; wen_clr = 0;
  endtask

  task automatic commit(logic [7:0] d);
    srw_open = 1; step();
    srw_valid = 1; srw_data = d; step();
    srw_valid = 0; srw_open = 0;
  endtask

  task automatic op(logic [1:0] k, logic [16:0] a, bit ea, logic [3:0] em, string tag);
    op_valid = 1; op_kind = k; op_addr = a; step(); op_valid = 0;
    chk(dec_valid == 1 && dec_allow == ea, tag, dec_allow, ea);
    chk(dec_mask == em, tag, dec_mask, em);
  endtask

  task automatic finish_op();
    done = 1; step(); done = 0;
  endtask

  initial begin
    steps(2);
    rst_n = 1;
    step();
    chk(status == 8'h00, "R1 reset status", status, 8'h00);
    chk(dec_valid == 0, "R1 no verdict", dec_valid, 0);
    #1 chk(op_ready && srw_ready, "R1 ready", {op_ready, srw_ready}, 2'b11);

    wen(1, 0);
    chk(status == 8'h02, "R3 wen set", status, 8'h02);
    wp_n = 0; steps(3);
    wen(0, 1);
    chk(status == 8'h00, "R3 wen clear with pin low", status, 8'h00);
    wp_n = 1; steps(3);

    op(2'd0, 17'h00010, 0, 4'h0, "R5 program without wen");
    wen(1, 0);
    op(2'd0, 17'h1FFFF, 1, 4'h8, "R4 level 00 top sector open");
    chk(status == 8'h03, "R6 busy after allow", status, 8'h03);
    wen(0, 1);
    chk(status == 8'h03, "R3 strobe ignored while busy", status, 8'h03);
    steps(2);
    finish_op();
    chk(status == 8'h00, "R6 end clears busy and wen", status, 8'h00);
    finish_op();
    chk(status == 8'h00, "R6 stray done ignored", status, 8'h00);

    wen(1, 0);
    commit(8'hFC);
    chk(status == 8'h8F, "R7 fields loaded, extra bits dropped", status, 8'h8F);
    steps(SRW - 1);
    chk(status[0] == 1'b1, "R8 still busy at last cycle", status[0], 1);
    step();
    chk(status == 8'h8C, "R8 cycle end clears wen", status, 8'h8C);

    wen(1, 0);
    op(2'd0, 17'h00000, 0, 4'h0, "R4 level 11 locks sector 0");
    op(2'd2, 17'h00000, 0, 4'h0, "R4 level 11 chip erase denied");
    chk(status == 8'h8E, "R7 denial keeps wen", status, 8'h8E);

    commit(8'h84);
    steps(SRW);
    chk(status == 8'h84, "R7 level 01 stored", status, 8'h84);
    wen(1, 0);
    op(2'd1, 17'h17FFF, 1, 4'h4, "R4 level 01 below boundary");
    finish_op();
    wen(1, 0);
    op(2'd0, 17'h18000, 0, 4'h0, "R4 level 01 boundary locked");
    op(2'd2, 17'h18000, 1, 4'h7, "R5 chip erase unlocked mask");
    finish_op();

    wp_n = 0; steps(3);
    wen(1, 0);
    commit(8'h00);
    steps(SRW + 2);
    chk(status == 8'h86, "R10 pin protection after sync", status, 8'h86);
    op(2'd0, 17'h00100, 1, 4'h1, "R5 pin has no array effect");
    finish_op();
    wp_n = 1; steps(3);

    wen(1, 0);
    srw_open = 1; step();
    wp_n = 0; steps(3);
    wp_n = 1; steps(4);
    srw_valid = 1; srw_data = 8'h80; step();
    srw_valid = 0; srw_open = 0;
    steps(2);
    chk(status == 8'h86, "R9 glitch voids frame", status, 8'h86);

    commit(8'h00);
    steps(SRW);
    chk(status == 8'h00, "R7 clean frame accepted", status, 8'h00);

    wp_n = 0; steps(3);
    wen(1, 0);
    commit(8'h08);
    steps(SRW);
    chk(status == 8'h08, "R12 disarmed pin ignored", status, 8'h08);
    wp_n = 1; steps(3);

    wen(1, 0);
    op(2'd3, 17'h00000, 0, 4'h0, "R5 reserved kind denied");
    op(2'd0, 17'h00000, 1, 4'h1, "R4 level 10 low sector open");
    #1 chk(!op_ready && !srw_ready, "R11 busy drops ready", {op_ready, srw_ready}, 0);
    finish_op();
    op_valid = 1; op_kind = 2'd0; op_addr = 17'h10000;
    #1 chk(!srw_ready, "R11 request has priority", srw_ready, 0);
    step(); op_valid = 0;
    chk(dec_valid && !dec_allow, "R4 level 10 sector 2 locked", dec_allow, 0);
    steps(2);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule